// File: doc/BRIEF.md
# Single-Cycle Integer Core (Eight-Instruction Subset)

This block is a 32-bit processor that retires one instruction on every clock edge. It supports a small register-to-register and memory subset: add, subtract, bitwise and, bitwise or, signed set-less-than, word load, word store and branch-if-equal. Within one cycle it does the following:

- takes the word that the program counter selects from an internal instruction array;
- reads two operands from a 32-entry register file;
- runs the ALU;
- optionally reads or writes an internal data array;
- writes one result back.

The testbench preloads both arrays before reset is released.

Control is decoded in two stages. The first stage sees only the opcode. It produces the datapath steering lines and a 2-bit ALU class: add, subtract, or "use the function field". The second stage combines that class with the R-format function field and chooses the ALU operation. Every register and memory write that commits is also driven on output ports, so the sequence of architectural effects can be observed from outside the block.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC becomes `RESET_PC` (default 0). During that time `wb_en_o` and `st_en_o` stay low, so no register or memory write commits.
- R2: With opcode 0 in bits 31:26, funct 0x20 writes rs+rt and funct 0x22 writes rs−rt to register rd (bits 15:11). Sources are rs in bits 25:21 and rt in bits 20:16. Both results wrap modulo 2^32.
- R3: With opcode 0, funct 0x24 writes rs AND rt and funct 0x25 writes rs OR rt to rd.
- R4: With opcode 0, funct 0x2A writes 1 to rd when rs is less than rt as signed two's-complement values, and 0 otherwise.
- R5: Opcode 35 (load) writes rt with the data word at byte address rs + sign-extended bits 15:0. The low two address bits are ignored.
- R6: Opcode 43 (store) writes the value of rt to the data word at rs + sign-extended bits 15:0, and writes no register.
- R7: Opcode 4 compares rs with rt. When they are equal, the next PC is PC+4+(sign-extended bits 15:0 shifted left by 2); otherwise it is PC+4. No register or memory write takes place.
- R8: Register 0 always reads as zero. A write aimed at it is dropped, and `wb_en_o` stays low.
- R9: Any opcode other than 0, 4, 35 and 43 writes no register and no memory, and advances the PC by 4.
- R10: Every instruction commits in the cycle it is fetched. A result is therefore an operand of the very next instruction, and a stored word is returned by a load that follows it directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_o | output | 32 | Address of the instruction in flight |
| instr_o | output | 32 | Instruction word in flight |
| wb_en_o | output | 1 | A register write commits at the next edge |
| wb_idx_o | output | 5 | Destination register of that write |
| wb_data_o | output | 32 | Value being written |
| st_en_o | output | 1 | A data-memory store commits at the next edge |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Word being stored |

## Verification
The bench sweeps all five register operations over every pair of six preloaded operands. The operands include the signed extremes, so a set-less-than that compares unsigned, or a subtract without wraparound, gives a wrong writeback value. It checks loads and stores with negative offsets and with a misaligned address, and follows each store directly with a load of the same word; a design that fails to sign-extend the offset, or that commits a store late, returns the wrong data. It checks taken and untaken branches and a backward branch; a design that forgets the shift by two lands on the wrong PC. It also checks writes aimed at register 0, unknown opcodes whose fields look like writes, and a reset asserted mid-program; a design without the correct gating shows a stray `wb_en_o` or `st_en_o`.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

   localparam int XLEN  = 32;
   localparam int RIDXW = 5;

   localparam logic [5:0] OPC_RTYPE = 6'd0;
   localparam logic [5:0] OPC_BEQ   = 6'd4;
   localparam logic [5:0] OPC_LOAD  = 6'd35;
   localparam logic [5:0] OPC_STORE = 6'd43;

   localparam logic [5:0] FN_ADD = 6'h20;
   localparam logic [5:0] FN_SUB = 6'h22;
   localparam logic [5:0] FN_AND = 6'h24;
   localparam logic [5:0] FN_OR  = 6'h25;
   localparam logic [5:0] FN_SLT = 6'h2A;

   typedef enum logic [1:0] {
      CLS_ADD   = 2'b00,
      CLS_SUB   = 2'b01,
      CLS_FUNCT = 2'b10
   } alu_class_e;

   typedef enum logic [3:0] {
      ALU_AND = 4'b0000,
      ALU_OR  = 4'b0001,
      ALU_ADD = 4'b0010,
      ALU_SUB = 4'b0110,
      ALU_SLT = 4'b0111
   } alu_sel_e;

   typedef struct packed {
      logic       dst_is_rd;
      logic       src_is_imm;
      logic       wb_from_mem;
      logic       reg_we;
      logic       mem_rd;
      logic       mem_we;
      logic       is_branch;
      alu_class_e alu_class;
   } ctrl_t;

endpackage

// File: rtl/sc_core_main_dec.sv
module sc_core_main_dec
   import sc_core_pkg::*;
(
   input  logic [5:0] opc_i,
   output ctrl_t      ctrl_o
);

   always_comb begin
      ctrl_o = '{dst_is_rd: 1'b0, src_is_imm: 1'b0, wb_from_mem: 1'b0,
                 reg_we: 1'b0, mem_rd: 1'b0, mem_we: 1'b0,
                 is_branch: 1'b0, alu_class: CLS_ADD};
      case (opc_i)
         OPC_RTYPE: begin
            ctrl_o.dst_is_rd = 1'b1;
            ctrl_o.reg_we    = 1'b1;
            ctrl_o.alu_class = CLS_FUNCT;
         end
         OPC_LOAD: begin
            ctrl_o.src_is_imm  = 1'b1;
            ctrl_o.wb_from_mem = 1'b1;
            ctrl_o.reg_we      = 1'b1;
            ctrl_o.mem_rd      = 1'b1;
         end
         OPC_STORE: begin
            ctrl_o.src_is_imm = 1'b1;
            ctrl_o.mem_we     = 1'b1;
         end
         OPC_BEQ: begin
            ctrl_o.is_branch = 1'b1;
            ctrl_o.alu_class = CLS_SUB;
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/sc_core_alu_ctl.sv
module sc_core_alu_ctl
   import sc_core_pkg::*;
(
   input  alu_class_e cls_i,
   input  logic [5:0] funct_i,
   output alu_sel_e   sel_o
);

   always_comb begin
      sel_o = ALU_ADD;
      case (cls_i)
         CLS_SUB:   sel_o = ALU_SUB;
         CLS_FUNCT: begin
            case (funct_i)
               FN_SUB:  sel_o = ALU_SUB;
               FN_AND:  sel_o = ALU_AND;
               FN_OR:   sel_o = ALU_OR;
               FN_SLT:  sel_o = ALU_SLT;
               default: sel_o = ALU_ADD;
            endcase
         end
         default:   sel_o = ALU_ADD;
      endcase
   end

endmodule

// File: rtl/sc_core_alu.sv
module sc_core_alu
   import sc_core_pkg::*;
#(
   parameter int W = XLEN
) (
   input  alu_sel_e       sel_i,
   input  logic [W-1:0]   a_i,
   input  logic [W-1:0]   b_i,
   output logic [W-1:0]   res_o,
   output logic           zero_o
);

   always_comb begin
      case (sel_i)
         ALU_AND: res_o = a_i & b_i;
         ALU_OR:  res_o = a_i | b_i;
         ALU_SUB: res_o = a_i - b_i;
         ALU_SLT: res_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
         default: res_o = a_i + b_i;
      endcase
   end

   assign zero_o = (res_o == '0);

endmodule

// File: rtl/sc_core_regfile.sv
module sc_core_regfile #(
   parameter int W     = 32,
   parameter int NREGS = 32,
   localparam int IW   = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          we_i,
   input  logic [IW-1:0] widx_i,
   input  logic [W-1:0]  wdata_i,
   input  logic [IW-1:0] ra_i,
   input  logic [IW-1:0] rb_i,
   output logic [W-1:0]  qa_o,
   output logic [W-1:0]  qb_o
);

   if (NREGS < 2 || (NREGS & (NREGS - 1)) != 0) begin : g_bad_nregs
      $error("sc_core_regfile: NREGS must be a power of two >= 2");
   end

   logic [W-1:0] rbus [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      if (g == 0) begin : g_zero
         assign rbus[g] = '0;
      end else begin : g_store
         logic [W-1:0] q;
         always_ff @(posedge clk) begin
            if (we_i && widx_i == IW'(g)) q <= wdata_i;
         end
         assign rbus[g] = q;
      end
   end

   assign qa_o = rbus[ra_i];
   assign qb_o = rbus[rb_i];

endmodule

// File: rtl/sc_core_imem.sv
module sc_core_imem #(
   parameter int W     = 32,
   parameter int DEPTH = 512,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic [AW-1:0] widx_i,
   output logic [W-1:0]  word_o
);

   logic [W-1:0] mem_q [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] = '0;
   end

   assign word_o = mem_q[widx_i];

endmodule

// File: rtl/sc_core_dmem.sv
module sc_core_dmem #(
   parameter int W     = 32,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          re_i,
   input  logic          we_i,
   input  logic [AW-1:0] widx_i,
   input  logic [W-1:0]  wdata_i,
   output logic [W-1:0]  rdata_o
);

   logic [W-1:0] mem_q [DEPTH];

   initial begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] = '0;
   end

   always_ff @(posedge clk) begin
      if (we_i) mem_q[widx_i] <= wdata_i;
   end

   assign rdata_o = re_i ? mem_q[widx_i] : '0;

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_core_pkg::*;
#(
   parameter int          IMEM_DEPTH = 512,
   parameter int          DMEM_DEPTH = 64,
   parameter logic [31:0] RESET_PC   = 32'h0
) (
   input  logic        clk,
   input  logic        rst,
   output logic [31:0] pc_o,
   output logic [31:0] instr_o,
   output logic        wb_en_o,
   output logic [4:0]  wb_idx_o,
   output logic [31:0] wb_data_o,
   output logic        st_en_o,
   output logic [31:0] st_addr_o,
   output logic [31:0] st_data_o
);

   localparam int IAW = $clog2(IMEM_DEPTH);
   localparam int DAW = $clog2(DMEM_DEPTH);

   if (IMEM_DEPTH < 4 || (IMEM_DEPTH & (IMEM_DEPTH - 1)) != 0) begin : g_bad_imem
      $error("sc_core: IMEM_DEPTH must be a power of two >= 4");
   end
   if (DMEM_DEPTH < 4 || (DMEM_DEPTH & (DMEM_DEPTH - 1)) != 0) begin : g_bad_dmem
      $error("sc_core: DMEM_DEPTH must be a power of two >= 4");
   end
   if (RESET_PC[1:0] != 2'b00) begin : g_bad_rpc
      $error("sc_core: RESET_PC must be word aligned");
   end

   logic [XLEN-1:0]  pc_q, pc_next, pc_plus4, br_target;
   logic [XLEN-1:0]  instr, imm_sx;
   logic [5:0]       opc, funct;
   logic [RIDXW-1:0] f_rs, f_rt, f_rd, dst_idx;
   ctrl_t            ctrl;
   alu_sel_e         alu_sel;
   logic [XLEN-1:0]  rs_val, rt_val, opb, alu_res, mem_rdata, wb_val;
   logic             alu_zero, wb_commit, st_commit, take_br;

   // fetch
   sc_core_imem #(.W(XLEN), .DEPTH(IMEM_DEPTH)) u_imem (
      .widx_i (pc_q[IAW+1:2]),
      .word_o (instr)
   );

   assign opc    = instr[31:26];
   assign f_rs   = instr[25:21];
   assign f_rt   = instr[20:16];
   assign f_rd   = instr[15:11];
   assign funct  = instr[5:0];
   assign imm_sx = {{(XLEN-16){instr[15]}}, instr[15:0]};

   // two-level control
   sc_core_main_dec u_dec (
      .opc_i  (opc),
      .ctrl_o (ctrl)
   );

   sc_core_alu_ctl u_aluctl (
      .cls_i   (ctrl.alu_class),
      .funct_i (funct),
      .sel_o   (alu_sel)
   );

   // operands
   assign dst_idx   = ctrl.dst_is_rd ? f_rd : f_rt;
   assign wb_commit = ctrl.reg_we && !rst && (dst_idx != '0);
   assign st_commit = ctrl.mem_we && !rst;

   sc_core_regfile #(.W(XLEN), .NREGS(2**RIDXW)) u_rf (
      .clk     (clk),
      .we_i    (wb_commit),
      .widx_i  (dst_idx),
      .wdata_i (wb_val),
      .ra_i    (f_rs),
      .rb_i    (f_rt),
      .qa_o    (rs_val),
      .qb_o    (rt_val)
   );

   assign opb = ctrl.src_is_imm ? imm_sx : rt_val;

   sc_core_alu #(.W(XLEN)) u_alu (
      .sel_i  (alu_sel),
      .a_i    (rs_val),
      .b_i    (opb),
      .res_o  (alu_res),
      .zero_o (alu_zero)
   );

   // data access
   sc_core_dmem #(.W(XLEN), .DEPTH(DMEM_DEPTH)) u_dmem (
      .clk     (clk),
      .re_i    (ctrl.mem_rd),
      .we_i    (st_commit),
      .widx_i  (alu_res[DAW+1:2]),
      .wdata_i (rt_val),
      .rdata_o (mem_rdata)
   );

   assign wb_val = ctrl.wb_from_mem ? mem_rdata : alu_res;

   // next PC
   assign pc_plus4  = pc_q + 32'd4;
   assign br_target = pc_plus4 + {imm_sx[XLEN-3:0], 2'b00};
   assign take_br   = ctrl.is_branch && alu_zero;
   assign pc_next   = take_br ? br_target : pc_plus4;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_PC;
      else     pc_q <= pc_next;
   end

   // observation ports
   assign pc_o      = pc_q;
   assign instr_o   = instr;
   assign wb_en_o   = wb_commit;
   assign wb_idx_o  = dst_idx;
   assign wb_data_o = wb_val;
   assign st_en_o   = st_commit;
   assign st_addr_o = alu_res;
   assign st_data_o = rt_val;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk #(
   parameter logic [31:0] RESET_PC = 32'h0
) (
   input logic        clk,
   input logic        rst,
   input logic [31:0] pc_i,
   input logic [5:0]  opc_i,
   input logic        wb_en_i,
   input logic [4:0]  wb_idx_i,
   input logic        st_en_i
);

   // R1
   reset_pc_chk: assert property (@(posedge clk) rst |=> pc_i == RESET_PC);

   // R1
   reset_quiet_chk: assert property (@(posedge clk) rst |-> (!wb_en_i && !st_en_i));

   // R8
   zero_dest_chk: assert property (@(posedge clk) disable iff (rst)
      wb_en_i |-> wb_idx_i != 5'd0);

   // R6
   store_nowb_chk: assert property (@(posedge clk) disable iff (rst)
      st_en_i |-> !wb_en_i);

   // R7
   branch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (opc_i == 6'd4) |-> (!wb_en_i && !st_en_i));

   // R9
   unknown_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (opc_i != 6'd0 && opc_i != 6'd4 && opc_i != 6'd35 && opc_i != 6'd43)
      |-> (!wb_en_i && !st_en_i));

   // R10
   seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
      (opc_i != 6'd4) |=> pc_i == $past(pc_i) + 32'd4);

endmodule

bind sc_core sc_core_chk #(.RESET_PC(RESET_PC)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .pc_i     (pc_o),
   .opc_i    (instr_o[31:26]),
   .wb_en_i  (wb_en_o),
   .wb_idx_i (wb_idx_o),
   .st_en_i  (st_en_o)
);

// File: tb/test_sc_core.sv
module test_sc_core;

   localparam int IMEM = 512;
   localparam int DMEM = 64;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] pc_o, instr_o, wb_data_o, st_addr_o, st_data_o;
   logic        wb_en_o, st_en_o;
   logic [4:0]  wb_idx_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [31:0] prog   [IMEM];
   logic [31:0] ref_dm [DMEM];
   logic [31:0] ref_rf [32];
   logic [31:0] ref_pc;
   int          nprog = 0;

   always #5 clk = ~clk;

   sc_core #(.IMEM_DEPTH(IMEM), .DMEM_DEPTH(DMEM)) i_sc_core (
      .clk(clk), .rst(rst), .pc_o(pc_o), .instr_o(instr_o),
      .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o),
      .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h (pc %h)", req, act, exp, ref_pc);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd,
                                         input int rs, input int rt);
      return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt,
                                         input int rs, input int imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction

   task automatic emit(input logic [31:0] w);
      prog[nprog] = w;
      nprog++;
   endtask

   task automatic build();
      logic [5:0] fns [5];
      int k;
      fns = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
      for (int i = 0; i < DMEM; i++) ref_dm[i] = 32'h0;
      ref_dm[0]  = 32'h0;        ref_dm[1]  = 32'h1;
      ref_dm[2]  = 32'h5;        ref_dm[3]  = 32'hFFFF_FFFF;
      ref_dm[4]  = 32'd64;       ref_dm[5]  = 32'h7FFF_FFFF;
      ref_dm[6]  = 32'h8000_0000; ref_dm[7] = 32'h3;
      ref_dm[8]  = 32'hDEAD_BEEF; ref_dm[9] = 32'd12345;
      ref_dm[10] = 32'hFFFF_FFF9; ref_dm[11] = 32'h2;
      ref_dm[12] = 32'hF0F0_F0F0; ref_dm[13] = 32'h0F0F_0F0F;
      ref_dm[14] = 32'd100;      ref_dm[15] = 32'h55AA;
      // R5 loads r1..r15, then a negative offset off r5 (=64)
      for (int i = 0; i < 15; i++) emit(enc_i(6'd35, i + 1, 0, i * 4));
      emit(enc_i(6'd35, 16, 5, -8));
      // R2 R3 R4 sweep over operand pairs (r4,r5,r6 hold -1, 64, 0x7FFFFFFF)
      k = 0;
      for (int f = 0; f < 5; f++)
         for (int a = 1; a <= 7; a++)
            for (int b = 1; b <= 7; b++) begin
               if (a == 5 || b == 5) continue;
               k++;
               emit(enc_r(fns[f], (k % 23 == 0) ? 0 : 16 + (k % 14), a, b));
            end
      emit(enc_r(6'h2A, 17, 7, 6));      // R4 most negative < most positive
      emit(enc_r(6'h2A, 18, 6, 7));
      // R8 write to r0 then read it
      emit(enc_r(6'h20, 0, 1, 3));
      emit(enc_r(6'h20, 30, 0, 0));
      emit(enc_i(6'd35, 0, 0, 8));
      emit(enc_r(6'h25, 29, 0, 3));
      // R10 back-to-back dependency and store then load
      emit(enc_r(6'h20, 21, 6, 7));
      emit(enc_r(6'h22, 22, 21, 6));
      emit(enc_i(6'd43, 22, 0, 80));     // R6
      emit(enc_i(6'd35, 23, 0, 80));
      emit(enc_i(6'd43, 9, 5, -4));      // R6 negative offset
      emit(enc_i(6'd35, 24, 5, -4));
      emit(enc_i(6'd35, 25, 0, 83));     // R5 low bits ignored
      for (int i = 17; i <= 24; i++) emit(enc_i(6'd43, i, 0, 96 + 4 * (i - 17)));
      for (int i = 17; i <= 24; i++) emit(enc_i(6'd35, 41 - i, 0, 96 + 4 * (i - 17)));
      // R7 branches
      emit(enc_i(6'd4, 2, 1, 1));        // not taken
      emit(enc_r(6'h20, 26, 2, 3));
      emit(enc_i(6'd4, 4, 4, 1));        // taken, skips next
      emit(enc_r(6'h20, 26, 0, 0));
      emit(enc_i(6'd4, 7, 6, 1));        // not taken
      emit(enc_i(6'd4, 0, 0, 2));        // to p+3
      emit(enc_r(6'h20, 27, 3, 3));      // p+1
      emit(enc_i(6'd4, 0, 0, 2));        // p+2 -> p+5
      emit(enc_i(6'd4, 0, 0, -3));       // p+3 -> p+1
      emit(enc_i(6'd43, 3, 0, 0));       // p+4 skipped
      // R9 unknown opcodes with write-looking fields
      emit(enc_i(6'd8, 20, 1, 4));
      emit(enc_i(6'd2, 21, 3, 0));
      emit(enc_i(6'd63, 22, 3, 8));
      emit(enc_i(6'd42, 22, 3, 8));
      emit(enc_r(6'h20, 28, 20, 21));
      emit(enc_i(6'd4, 0, 0, -1));       // halt loop
   endtask

   task automatic step();
      logic [31:0] w, a, b, res, ea, npc, sx;
      logic [5:0]  op, fn;
      int          rs, rt, rd;
      string       tag;
      bit          exp_wb, exp_st;
      int          exp_idx;
      logic [31:0] exp_data;
      w  = prog[ref_pc[10:2]];
      op = w[31:26]; fn = w[5:0];
      rs = int'(w[25:21]); rt = int'(w[20:16]); rd = int'(w[15:11]);
      sx = {{16{w[15]}}, w[15:0]};
      a  = ref_rf[rs]; b = ref_rf[rt];
      ea = a + sx;
      npc = ref_pc + 32'd4;
      exp_wb = 1'b0; exp_st = 1'b0; exp_idx = 0; exp_data = '0; res = '0;
      tag = "R9";
      chk(pc_o == ref_pc, "R10 pc", pc_o, ref_pc);
      chk(instr_o == w, "R10 fetch", instr_o, w);
      case (op)
         6'd0: begin
            case (fn)
               6'h20: begin res = a + b; tag = "R2"; end
               6'h22: begin res = a - b; tag = "R2"; end
               6'h24: begin res = a & b; tag = "R3"; end
               6'h25: begin res = a | b; tag = "R3"; end
               6'h2A: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R4"; end
               default: res = a + b;
            endcase
            exp_idx = rd; exp_data = res; exp_wb = (rd != 0);
         end
         6'd35: begin
            tag = "R5";
            exp_idx = rt; exp_data = ref_dm[ea[7:2]]; exp_wb = (rt != 0);
         end
         6'd43: begin
            tag = "R6"; exp_st = 1'b1;
         end
         6'd4: begin
            tag = "R7";
            if (a == b) npc = ref_pc + 32'd4 + {sx[29:0], 2'b00};
         end
         default: tag = "R9";
      endcase
      if ((op == 6'd0 || op == 6'd35) && exp_idx == 0) tag = "R8";
      chk(wb_en_o == exp_wb, {tag, " wb_en"}, 32'(wb_en_o), 32'(exp_wb));
      if (exp_wb) begin
         chk(wb_idx_o == 5'(exp_idx), {tag, " wb_idx"}, 32'(wb_idx_o), 32'(exp_idx));
         chk(wb_data_o == exp_data, {tag, " wb_data"}, wb_data_o, exp_data);
         ref_rf[exp_idx] = exp_data;
      end
      chk(st_en_o == exp_st, {tag, " st_en"}, 32'(st_en_o), 32'(exp_st));
      if (exp_st) begin
         chk(st_addr_o == ea, "R6 st_addr", st_addr_o, ea);
         chk(st_data_o == b, "R6 st_data", st_data_o, b);
         ref_dm[ea[7:2]] = b;
      end
      ref_pc = npc;
   endtask

   initial begin
      #(20000 * 10);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         summary();
      end
   end

   initial begin
      int halt_seen;
      logic [31:0] halt_pc;
      build();
      halt_pc = 32'((nprog - 1) * 4);
      for (int i = 0; i < 32; i++) ref_rf[i] = '0;
      #1;
      for (int i = 0; i < IMEM; i++) i_sc_core.u_imem.mem_q[i] = (i < nprog) ? prog[i] : 32'h0;
      for (int i = 0; i < DMEM; i++) i_sc_core.u_dmem.mem_q[i] = ref_dm[i];
      repeat (3) @(posedge clk);
      @(negedge clk);
      ref_pc = 32'h0;
      // R1 reset state
      chk(pc_o == 32'h0, "R1 pc", pc_o, 32'h0);
      chk(!wb_en_o, "R1 wb_en", 32'(wb_en_o), 32'h0);
      chk(!st_en_o, "R1 st_en", 32'(st_en_o), 32'h0);
      rst = 1'b0;
      halt_seen = 0;
      for (int c = 0; c < 2000 && halt_seen < 3; c++) begin
         #1;
         if (ref_pc == halt_pc) halt_seen++;
         step();
         @(negedge clk);
      end
      chk(halt_seen == 3, "R7 halt reached", 32'(halt_seen), 32'd3);
      // R1 reset mid-program: first instruction would write r1
      rst = 1'b1;
      #1;
      chk(!wb_en_o, "R1 wb_en mid", 32'(wb_en_o), 32'h0);
      chk(!st_en_o, "R1 st_en mid", 32'(st_en_o), 32'h0);
      @(negedge clk);
      chk(pc_o == 32'h0, "R1 pc mid", pc_o, 32'h0);
      chk(!wb_en_o, "R1 wb_en held", 32'(wb_en_o), 32'h0);
      done = 1'b1;
      summary();
   end

endmodule